// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block sits in front of a downstream PLL and decides which of two reference clocks feeds it. It samples both references and the PLL feedback clock on a fast sampling clock and watches for edges. A reference that shows no edge between two consecutive feedback rising edges is treated as stuck, and its bad flag latches. A feedback clock that shows no edge for a programmable number of sampling cycles marks both references bad at once.

With automatic switching enabled (override low), the first failure moves the selection to the other input. The flags and the selection then stay latched until an alarm reset is fired. The alarm reset acts on its falling edge and produces a one-cycle internal pulse. That pulse clears the flags and reloads the selection from the select pin. With override high, the selection simply follows the select pin, while monitoring continues.

A fallback request tells the downstream logic to drop to a low output frequency when no usable reference is left. A one-cycle switch pulse marks every change of selection.

Top module: `refclk_failover`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, both bad flags, the selected-input output, the switch pulse and the fallback request are 0.
- R2: A reference that has no edge (synchronised) between two consecutive synchronised feedback rising edges latches its bad flag high. The first feedback rising edge after reset or after an alarm pulse only arms the check. A set flag stays set until an alarm pulse.
- R3: If the synchronised feedback clock has no edge for STALL_CYC sampling cycles, both bad flags latch high.
- R4: The selected-input output reads 0 for reference 0 and 1 for reference 1, and the select pin uses the same encoding. While neither flag is set and no failure is detected, the selection takes the select pin value one cycle after it is sampled.
- R5: A falling edge on the alarm reset, after its two-flop synchroniser, produces exactly one pulse. The pulse clears both flags and loads the selection from the select pin. A rising edge, or the pin held low, has no further effect.
- R6: With override low, the first failure moves the selection to the input that is not bad. From then on the selection holds until an alarm pulse, whatever the select pin does.
- R7: With override high, the selection follows the select pin one cycle later even when flags are set, and the flags are still updated.
- R8: If both references are detected bad in the same cycle while no flag is set, the selection becomes 0. This includes the case of both references dead when an alarm pulse fires: both flags set again after one full feedback period.
- R9: With override low, the fallback request equals the AND of the two bad flags.
- R10: With override high, the fallback request rises when the feedback stall is detected. It stays high for at least HOLD_CYC cycles from that point, or for as long as the stall lasts, whichever is longer.
- R11: The switch output is high for exactly the one cycle in which a new selection first appears on the selected-input output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, at least 4x the reference frequency |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref0_i | input | 1 | Reference clock 0 |
| ref1_i | input | 1 | Reference clock 1 |
| fb_i | input | 1 | Feedback clock from the PLL output |
| sel_i | input | 1 | Primary select: 0 picks reference 0, 1 picks reference 1 |
| ovr_i | input | 1 | Manual override: 1 disables automatic switching |
| alarm_rst_ni | input | 1 | Alarm reset, active on its falling edge |
| bad0_o | output | 1 | Latched bad flag for reference 0 |
| bad1_o | output | 1 | Latched bad flag for reference 1 |
| sel_ref_o | output | 1 | Reference currently driving the PLL |
| switch_o | output | 1 | One-cycle pulse on every change of selection |
| fallback_o | output | 1 | Request for low-frequency output mode |

## Verification
The assertions assume that the select and override pins are synchronous to the sampling clock. They also assume the sampling clock is fast enough to see every edge of the references and the feedback, and that a healthy reference toggles at least once per feedback period. The stimulus meets these conditions by changing every input just after a sampling edge. References toggle every 4 cycles and the feedback every 8, so a healthy reference shows several edges per feedback period. Failures are made only by stopping a toggle outright.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int NREF = 2;
  typedef enum logic {REF_A = 1'b0, REF_B = 1'b1} ref_pick_e;
endpackage

// File: rtl/rcf_sync.sv
// Two-flop synchroniser plus one history flop for edge detection.
module rcf_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic cur_o,
  output logic prev_o
);
  localparam int DEPTH = 3;
  logic [DEPTH-1:0] stg_q, stg_d;

  always_comb begin
    stg_d = {stg_q[DEPTH-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {DEPTH{RST_VAL}};
    else         stg_q <= stg_d;
  end

  assign cur_o  = stg_q[DEPTH-2];
  assign prev_o = stg_q[DEPTH-1];
endmodule

// File: rtl/rcf_refmon.sv
// Per-reference edge-seen tracking across each feedback period.
module rcf_refmon #(
  parameter int NREF = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREF-1:0] edge_i,
  input  logic            fb_rise_i,
  input  logic            clr_i,
  output logic [NREF-1:0] stuck_o
);
  logic [NREF-1:0] seen_q, seen_d;
  logic            armed_q, armed_d;

  always_comb begin
    if (clr_i)          armed_d = 1'b0;
    else if (fb_rise_i) armed_d = 1'b1;
    else                armed_d = armed_q;
  end

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    always_comb begin
      if (clr_i || fb_rise_i) seen_d[g] = 1'b0;
      else                    seen_d[g] = seen_q[g] | edge_i[g];
    end
    assign stuck_o[g] = fb_rise_i & armed_q & ~(seen_q[g] | edge_i[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      seen_q  <= seen_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/rcf_fbwatch.sv
// Feedback stall counter and minimum-hold timer.
module rcf_fbwatch #(
  parameter int STALL_CYC = 32,
  parameter int HOLD_CYC  = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fb_edge_i,
  input  logic clr_i,
  output logic dead_o,
  output logic hold_o
);
  localparam int CW = $clog2(STALL_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIM  = CW'(STALL_CYC);
  localparam logic [HW-1:0] HLOAD = HW'(HOLD_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    if (clr_i || fb_edge_i) cnt_d = '0;
    else if (cnt_q == LIM)  cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_d == LIM && cnt_q != LIM) hold_d = HLOAD;
    else if (hold_q != '0)            hold_d = hold_q - 1'b1;
    else                              hold_d = hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign dead_o = (cnt_q == LIM);
  assign hold_o = dead_o | (hold_q != '0);
endmodule

// File: rtl/rcf_selctl.sv
// Bad-flag latches, selection policy, switch pulse and fallback request.
module rcf_selctl
  import rcf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREF-1:0] stuck_i,
  input  logic            dead_i,
  input  logic            hold_i,
  input  logic            alarm_i,
  input  logic            sel_i,
  input  logic            ovr_i,
  output logic [NREF-1:0] bad_o,
  output logic            sel_o,
  output logic            switch_o,
  output logic            fallback_o
);
  logic [NREF-1:0] bad_q, bad_d;
  ref_pick_e       sel_q, sel_d;
  logic            sw_q, sw_d;

  always_comb begin
    if (alarm_i) bad_d = '0;
    else         bad_d = bad_q | stuck_i | {NREF{dead_i}};
  end

  always_comb begin
    sel_d = sel_q;
    if (alarm_i || ovr_i) begin
      sel_d = ref_pick_e'(sel_i);
    end else if (bad_q == '0) begin
      if (&bad_d)        sel_d = REF_A;
      else if (bad_d[0]) sel_d = REF_B;
      else if (bad_d[1]) sel_d = REF_A;
      else               sel_d = ref_pick_e'(sel_i);
    end
    sw_d = (sel_d != sel_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_q <= '0;
      sel_q <= REF_A;
      sw_q  <= 1'b0;
    end else begin
      bad_q <= bad_d;
      sel_q <= sel_d;
      sw_q  <= sw_d;
    end
  end

  assign bad_o      = bad_q;
  assign sel_o      = sel_q;
  assign switch_o   = sw_q;
  assign fallback_o = ovr_i ? hold_i : (&bad_q);
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
  import rcf_pkg::*;
#(
  parameter int STALL_CYC = 32,
  parameter int HOLD_CYC  = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref0_i,
  input  logic ref1_i,
  input  logic fb_i,
  input  logic sel_i,
  input  logic ovr_i,
  input  logic alarm_rst_ni,
  output logic bad0_o,
  output logic bad1_o,
  output logic sel_ref_o,
  output logic switch_o,
  output logic fallback_o
);
  logic [NREF-1:0] ref_in, ref_cur, ref_prev, ref_edge, stuck, bad;
  logic fb_cur, fb_prev, fb_edge, fb_rise;
  logic al_cur, al_prev, alarm_pulse;
  logic fb_dead, fb_hold;

  assign ref_in = {ref1_i, ref0_i};

  for (genvar g = 0; g < NREF; g++) begin : g_rsync
    rcf_sync #(.RST_VAL(1'b0)) u_sync (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(ref_in[g]),
      .cur_o (ref_cur[g]), .prev_o(ref_prev[g])
    );
    assign ref_edge[g] = ref_cur[g] ^ ref_prev[g];
  end

  rcf_sync #(.RST_VAL(1'b0)) u_fbsync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fb_i), .cur_o(fb_cur), .prev_o(fb_prev)
  );
  assign fb_edge = fb_cur ^ fb_prev;
  assign fb_rise = fb_cur & ~fb_prev;

  rcf_sync #(.RST_VAL(1'b1)) u_alsync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(alarm_rst_ni), .cur_o(al_cur), .prev_o(al_prev)
  );
  assign alarm_pulse = al_prev & ~al_cur;

  rcf_refmon #(.NREF(NREF)) u_refmon (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(ref_edge), .fb_rise_i(fb_rise),
    .clr_i(alarm_pulse), .stuck_o(stuck)
  );

  rcf_fbwatch #(.STALL_CYC(STALL_CYC), .HOLD_CYC(HOLD_CYC)) u_fbwatch (
    .clk_i(clk_i), .rst_ni(rst_ni), .fb_edge_i(fb_edge), .clr_i(alarm_pulse),
    .dead_o(fb_dead), .hold_o(fb_hold)
  );

  rcf_selctl u_selctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .stuck_i(stuck), .dead_i(fb_dead),
    .hold_i(fb_hold), .alarm_i(alarm_pulse), .sel_i(sel_i), .ovr_i(ovr_i),
    .bad_o(bad), .sel_o(sel_ref_o), .switch_o(switch_o), .fallback_o(fallback_o)
  );

  assign bad0_o = bad[0];
  assign bad1_o = bad[1];
endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_i,
  input logic ovr_i,
  input logic bad0_o,
  input logic bad1_o,
  input logic sel_ref_o,
  input logic switch_o,
  input logic fallback_o,
  input logic alarm_pulse,
  input logic fb_dead
);
  a_r2_bad0_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad0_o && !alarm_pulse |=> bad0_o);
  a_r2_bad1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad1_o && !alarm_pulse |=> bad1_o);
  a_r3_stall_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_dead && !alarm_pulse |=> bad0_o && bad1_o);
  a_r5_alarm_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_pulse |=> !bad0_o && !bad1_o && (sel_ref_o == $past(sel_i)));
  a_r6_sel_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_i && (bad0_o || bad1_o) && !alarm_pulse |=> $stable(sel_ref_o));
  a_r7_ovr_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> sel_ref_o == $past(sel_i));
  a_r10_stall_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i && fb_dead |-> fallback_o);
  a_r11_switch_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> sel_ref_o != $past(sel_ref_o));
endmodule

bind refclk_failover refclk_failover_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .ovr_i(ovr_i),
  .bad0_o(bad0_o), .bad1_o(bad1_o), .sel_ref_o(sel_ref_o),
  .switch_o(switch_o), .fallback_o(fallback_o),
  .alarm_pulse(alarm_pulse), .fb_dead(fb_dead)
);

// File: tb/sim_refclk_failover.sv
`timescale 1ns/1ps
module sim_refclk_failover;
  localparam int STALL = 32;
  localparam int HOLD  = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref0 = 1'b0, ref1 = 1'b0, fb = 1'b0;
  logic sel = 1'b0, ovr = 1'b0, alarm = 1'b1;
  logic bad0, bad1, selr, sw, fbk;
  bit r0_run = 1, r1_run = 1, fb_run = 1, done = 0;
  int cyc = 0, n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  refclk_failover #(.STALL_CYC(STALL), .HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref0_i(ref0), .ref1_i(ref1), .fb_i(fb),
    .sel_i(sel), .ovr_i(ovr), .alarm_rst_ni(alarm),
    .bad0_o(bad0), .bad1_o(bad1), .sel_ref_o(selr), .switch_o(sw), .fallback_o(fbk)
  );

  // clock sources: references every 4 cycles, feedback every 8
  always @(posedge clk) begin
    #1;
    cyc++;
    if (r0_run && cyc % 4 == 0) ref0 = ~ref0;
    if (r1_run && cyc % 4 == 0) ref1 = ~ref1;
    if (fb_run && cyc % 8 == 0) fb = ~fb;
  end

  // behavioural reference model
  bit [3:0] h0, h1, hf, ha;
  bit m_seen0, m_seen1, m_arm, m_b0, m_b1, m_sel, m_sw;
  int m_cnt, m_hold;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0 = 0; h1 = 0; hf = 0; ha = 4'hF;
      m_seen0 = 0; m_seen1 = 0; m_arm = 0; m_b0 = 0; m_b1 = 0;
      m_sel = 0; m_sw = 0; m_cnt = 0; m_hold = 0;
    end else begin
      bit e0, e1, fe, fr, ap, s0, s1, dead, nb0, nb1, nsel;
      int ncnt;
      h0 = {h0[2:0], ref0}; h1 = {h1[2:0], ref1};
      hf = {hf[2:0], fb};   ha = {ha[2:0], alarm};
      e0 = h0[2] ^ h0[3]; e1 = h1[2] ^ h1[3];
      fe = hf[2] ^ hf[3]; fr = hf[2] & !hf[3];
      ap = ha[3] & !ha[2];
      s0 = fr && m_arm && !(m_seen0 || e0);
      s1 = fr && m_arm && !(m_seen1 || e1);
      dead = (m_cnt == STALL);
      ncnt = (ap || fe) ? 0 : (dead ? m_cnt : m_cnt + 1);
      if (ncnt == STALL && !dead) m_hold = HOLD;
      else if (m_hold != 0) m_hold = m_hold - 1;
      nb0 = ap ? 0 : (m_b0 || s0 || dead);
      nb1 = ap ? 0 : (m_b1 || s1 || dead);
      if (ap || ovr) nsel = sel;
      else if (!m_b0 && !m_b1) nsel = (nb0 && nb1) ? 0 : nb0 ? 1 : nb1 ? 0 : sel;
      else nsel = m_sel;
      m_sw = (nsel != m_sel);
      m_sel = nsel; m_b0 = nb0; m_b1 = nb1; m_cnt = ncnt;
      m_arm = ap ? 0 : (fr ? 1 : m_arm);
      m_seen0 = (ap || fr) ? 0 : (m_seen0 || e0);
      m_seen1 = (ap || fr) ? 0 : (m_seen1 || e1);
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 bad0 model", bad0, m_b0);
      chk("R2 bad1 model", bad1, m_b1);
      chk("R4 sel model", selr, m_sel);
      chk("R11 switch model", sw, m_sw);
      if (ovr) chk("R10 fallback model", fbk, (m_cnt == STALL) || (m_hold != 0));
      else     chk("R9 fallback model", fbk, m_b0 && m_b1);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fire_alarm();
    alarm = 1'b0; step(4); alarm = 1'b1; step(6);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset bad0", bad0, 0); chk("R1 reset bad1", bad1, 0);
    chk("R1 reset sel", selr, 0);  chk("R1 reset fallback", fbk, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release sel", selr, 0); chk("R1 after release switch", sw, 0);
    step(40);
    chk("R2 healthy bad0", bad0, 0); chk("R2 healthy bad1", bad1, 0);
    // R4 / R11: free selection and switch pulse
    sel = 1'b1;
    @(negedge clk); chk("R4 latency sel", selr, 0);
    @(negedge clk); chk("R4 sel follows", selr, 1); chk("R11 switch high", sw, 1);
    @(negedge clk); chk("R11 switch one cycle", sw, 0);
    step(2);
    // R6: selected reference fails, auto switch
    r1_run = 0; step(60);
    chk("R2 ref1 stuck flag", bad1, 1); chk("R6 moved to ref0", selr, 0);
    chk("R2 ref0 still good", bad0, 0);
    sel = 1'b0; step(5); sel = 1'b1; step(5);
    chk("R6 selection latched", selr, 0);
    // R5: alarm clears and reloads, rising edge has no effect
    r1_run = 1; step(20);
    alarm = 1'b0; step(8);
    chk("R5 flags cleared", bad1, 0); chk("R5 sel reloaded", selr, 1);
    r0_run = 0; step(60);
    chk("R2 ref0 stuck flag", bad0, 1); chk("R6 other input kept", selr, 1);
    alarm = 1'b1; step(10);
    chk("R5 rising edge ignored", bad0, 1);
    r0_run = 1; step(20); fire_alarm();
    chk("R5 second alarm clears", bad0, 0);
    // R7: override high
    ovr = 1'b1; step(4);
    r1_run = 0; step(60);
    chk("R7 flag still set", bad1, 1); chk("R7 sel follows pin", selr, 1);
    sel = 1'b0; step(3); chk("R7 sel tracks pin", selr, 0);
    r1_run = 1; step(20);
    // R3 / R10: short feedback stall
    fb_run = 0; step(45);
    chk("R3 stall flags bad0", bad0, 1); chk("R3 stall flags bad1", bad1, 1);
    chk("R10 fallback on stall", fbk, 1);
    fb_run = 1; step(40);
    chk("R10 fallback held min time", fbk, 1);
    step(100);
    chk("R10 fallback released", fbk, 0);
    // R10: long stall outlasts hold time
    fb_run = 0; step(180);
    chk("R10 fallback during long stall", fbk, 1);
    fb_run = 1; step(20);
    chk("R10 fallback drops after activity", fbk, 0);
    // R9: override low, both flags set
    ovr = 1'b0; step(2);
    chk("R9 fallback both bad", fbk, 1);
    fire_alarm();
    chk("R9 fallback cleared", fbk, 0);
    // R8: both references dead
    sel = 1'b1; step(20);
    r0_run = 0; r1_run = 0; step(60);
    chk("R8 both bad0", bad0, 1); chk("R8 both bad1", bad1, 1);
    chk("R8 sel to ref0", selr, 0); chk("R9 fallback both dead", fbk, 1);
    fire_alarm();
    chk("R8 alarm clears", bad0, 0); chk("R8 alarm reload sel", selr, 1);
    step(50);
    chk("R8 relatch bad0", bad0, 1); chk("R8 relatch bad1", bad1, 1);
    chk("R8 relatch sel ref0", selr, 0);
    r0_run = 1; r1_run = 1; step(20); fire_alarm(); step(40);
    chk("R2 clean end bad0", bad0, 0); chk("R2 clean end bad1", bad1, 0);
    chk("R4 clean end sel", selr, 1);
    finish_run();
  end
endmodule